// File: doc/BRIEF.md
# Memory ECC Error Logger

This block sits beside a DRAM controller and records the ECC error events that the controller reports. Each memory access that finds an error produces a one-cycle pulse on one of two inputs: one for a corrected single-bit error, one for an uncorrectable multi-bit error. The pulse comes with the physical address of the access and the index of the memory row it hit. The logger keeps the failing 4 KB page and a sticky flag for each error class. It also records, for each class, which row failed first. Software reads and clears these records through a small register port.

Each record freezes once it is taken, so software always sees the first failure of each class. A multi-bit error may still take over an address that is held for a single-bit error. Software clears a flag by writing a one to it. A two-bit integrity mode turns logging off or on. A command register selects which error classes raise a one-cycle system-error pulse when they are newly logged.

Register map (2-bit register address): 0 = error address, 1 = row status, 2 = command, 3 = integrity mode. Read data is registered: `reg_rdata` shows the register selected by `reg_addr` one clock later. A write happens on the clock edge where `reg_we` is high.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, all four registers read zero and `serr_o` is low. `reg_rdata` gives the register selected in the previous cycle.
- R2: In integrity mode 00, error pulses change no register and `serr_o` stays low, even with both command enables set.
- R3: In a logging mode, a single-bit error when no flags are held stores address bits 31:12 in bits 31:12 of the error address register (bits 11:2 read zero) and sets bit 0. It also sets bit 0 of the status register and stores the row in status bits 3:1.
- R4: In a logging mode, a multi-bit error sets bit 1 of the error address register and stores its address. It also sets status bit 4 and stores the row in status bits 7:5.
- R5: While a class flag is set, later errors of that class do not change that class's captured row. The stored address also stays unchanged.
- R6: A multi-bit error replaces an address held for a single-bit error. A single-bit error arriving while the multi-bit flag is held sets bit 0 but leaves the address unchanged.
- R7: Writing 1 to bit 0 or bit 1 of the error address register clears that flag. Writing 1 to status bit 0 or bit 4 clears that occurred flag. Writing 0 changes nothing. The two registers are cleared independently, and clearing leaves the stored rows in place.
- R8: When a clear and a new error of the same class arrive in the same cycle, the new error is logged with its address and row, and the flag stays set.
- R9: `serr_o` pulses high for exactly one cycle, one clock after an error is newly logged in the error address register. Command bit 0 enables this for single-bit errors and bit 1 enables it for multi-bit errors. An error whose flag is already held raises no pulse.
- R10: Integrity modes 01, 10 and 11 all enable logging.
- R11: The command and mode registers read back the written values in bits 1:0. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sbe_i | input | 1 | Single-bit (corrected) error pulse |
| mbe_i | input | 1 | Multi-bit (uncorrectable) error pulse |
| err_addr_i | input | 32 | Physical address of the failing access |
| err_row_i | input | 3 | Memory row of the failing access |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| serr_o | output | 1 | System-error pulse |

## Verification
The bench targets the moments when two rules meet. A held single-bit address is hit by a multi-bit error: a design that protects every held address would keep the stale page. A clear and a new error land in the same cycle: a design that gives the clear priority would drop the error and leave the flag low. A second error arrives while its class flag is held: a design without the freeze would overwrite the row and pulse `serr_o` again. Mode 00 is driven with both enables set, and zero-writes are applied to every flag, which exposes any logger that is not gated or not truly write-one-to-clear.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_CHECK = 2'b01,
    MODE_ECC   = 2'b10,
    MODE_SCRUB = 2'b11
  } integ_mode_e;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_MODE = 2'd3
  } reg_sel_e;

  localparam int NUM_CLASS = 2;
  localparam int CLS_SBE   = 0;
  localparam int CLS_MBE   = 1;
endpackage

// File: rtl/ecc_log_row.sv
// First-failing-row record for one error class.
module ecc_log_row #(
  parameter int ROW_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic             clr_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             flag_o,
  output logic [ROW_W-1:0] row_o
);
  logic             flag_q;
  logic [ROW_W-1:0] row_q;
  logic             take;

  // a clear in the same cycle frees the slot for the new event
  assign take = hit_i & (~flag_q | clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      row_q  <= '0;
    end else if (take) begin
      flag_q <= 1'b1;
      row_q  <= row_i;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign row_o  = row_q;

  // R5
  row_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> ($stable(row_q) && flag_q));
endmodule

// File: rtl/ecc_log_addr.sv
// Error page capture with sticky, write-one-to-clear class flags.
module ecc_log_addr #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sbe_hit_i,
  input  logic                       mbe_hit_i,
  input  logic                       clr_sbe_i,
  input  logic                       clr_mbe_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic [ADDR_W-1:PAGE_LSB]   page_o,
  output logic                       sbe_flag_o,
  output logic                       mbe_flag_o,
  output logic                       sbe_new_o,
  output logic                       mbe_new_o
);
  logic [ADDR_W-1:PAGE_LSB] page_q;
  logic                     sbe_q, mbe_q;
  logic                     sbe_free, mbe_free;
  logic                     sbe_new, mbe_new, grab;
  logic                     unused_low_bits;

  assign unused_low_bits = ^addr_i[PAGE_LSB-1:0];

  assign sbe_free = ~sbe_q | clr_sbe_i;
  assign mbe_free = ~mbe_q | clr_mbe_i;
  assign sbe_new  = sbe_hit_i & sbe_free;
  assign mbe_new  = mbe_hit_i & mbe_free;
  // multi-bit always wins the page; single-bit only when no multi-bit is held
  assign grab     = mbe_new | (sbe_new & mbe_free);

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      sbe_q  <= 1'b0;
      mbe_q  <= 1'b0;
    end else begin
      if (grab)
        page_q <= addr_i[ADDR_W-1:PAGE_LSB];
      if (sbe_new)        sbe_q <= 1'b1;
      else if (clr_sbe_i) sbe_q <= 1'b0;
      if (mbe_new)        mbe_q <= 1'b1;
      else if (clr_mbe_i) mbe_q <= 1'b0;
    end
  end

  assign page_o     = page_q;
  assign sbe_flag_o = sbe_q;
  assign mbe_flag_o = mbe_q;
  assign sbe_new_o  = sbe_new;
  assign mbe_new_o  = mbe_new;

  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mbe_q && !clr_mbe_i) |=> $stable(page_q));
  // R3
  sbe_set_chk: assert property (@(posedge clk) disable iff (rst)
    sbe_hit_i |=> sbe_q);
  // R7
  sbe_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_sbe_i && !sbe_hit_i) |=> !sbe_q);
  // R7
  mbe_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_mbe_i && !mbe_hit_i) |=> !mbe_q);
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12,
  parameter int ROW_W    = 3,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [ROW_W-1:0]  err_row_i,
  input  logic [1:0]        reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              serr_o
);
  localparam int STRIDE = ROW_W + 1;

  integ_mode_e              mode_q;
  logic [1:0]               cmd_q;
  logic                     log_en;
  logic [NUM_CLASS-1:0]     hit;
  logic [NUM_CLASS-1:0]     stat_clr;
  logic [NUM_CLASS-1:0]     stat_flag;
  logic [ROW_W-1:0]         stat_row [NUM_CLASS];
  logic                     wr_addr, wr_stat, wr_cmd, wr_mode;
  logic [ADDR_W-1:PAGE_LSB] page;
  logic                     sbe_flag, mbe_flag, sbe_new, mbe_new;
  logic [DATA_W-1:0]        rd_mux;
  logic                     serr_q;
  logic                     unused_wdata;

  assign unused_wdata = ^reg_wdata;

  assign log_en  = (mode_q != MODE_OFF);
  assign hit[CLS_SBE] = log_en & sbe_i;
  assign hit[CLS_MBE] = log_en & mbe_i;

  assign wr_addr = reg_we && (reg_addr == SEL_ADDR);
  assign wr_stat = reg_we && (reg_addr == SEL_STAT);
  assign wr_cmd  = reg_we && (reg_addr == SEL_CMD);
  assign wr_mode = reg_we && (reg_addr == SEL_MODE);

  ecc_log_addr #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .sbe_hit_i  (hit[CLS_SBE]),
    .mbe_hit_i  (hit[CLS_MBE]),
    .clr_sbe_i  (wr_addr & reg_wdata[0]),
    .clr_mbe_i  (wr_addr & reg_wdata[1]),
    .addr_i     (err_addr_i),
    .page_o     (page),
    .sbe_flag_o (sbe_flag),
    .mbe_flag_o (mbe_flag),
    .sbe_new_o  (sbe_new),
    .mbe_new_o  (mbe_new)
  );

  for (genvar g = 0; g < NUM_CLASS; g++) begin : g_row
    assign stat_clr[g] = wr_stat & reg_wdata[g*STRIDE];
    ecc_log_row #(.ROW_W(ROW_W)) u_row (
      .clk    (clk),
      .rst    (rst),
      .hit_i  (hit[g]),
      .clr_i  (stat_clr[g]),
      .row_i  (err_row_i),
      .flag_o (stat_flag[g]),
      .row_o  (stat_row[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= 2'b00;
      mode_q <= MODE_OFF;
    end else begin
      if (wr_cmd)  cmd_q  <= reg_wdata[1:0];
      if (wr_mode) mode_q <= integ_mode_e'(reg_wdata[1:0]);
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      SEL_ADDR: begin
        rd_mux[ADDR_W-1:PAGE_LSB] = page;
        rd_mux[1] = mbe_flag;
        rd_mux[0] = sbe_flag;
      end
      SEL_STAT: begin
        for (int c = 0; c < NUM_CLASS; c++) begin
          rd_mux[c*STRIDE]          = stat_flag[c];
          rd_mux[c*STRIDE+1 +: ROW_W] = stat_row[c];
        end
      end
      SEL_CMD:  rd_mux[1:0] = cmd_q;
      SEL_MODE: rd_mux[1:0] = mode_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      serr_q    <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      serr_q    <= (sbe_new & cmd_q[0]) | (mbe_new & cmd_q[1]);
    end
  end

  assign serr_o = serr_q;

  // R2
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_OFF) |=> !serr_o);
  // R9
  serr_enable_chk: assert property (@(posedge clk) disable iff (rst)
    serr_o |-> ($past(cmd_q) != 2'b00));
  // R9
  serr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    serr_o |-> (sbe_flag || mbe_flag));
endmodule

// File: tb/ecc_err_logger_tb.sv
`timescale 1ns/1ps
module ecc_err_logger_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sbe_i = 1'b0, mbe_i = 1'b0;
  logic [31:0] err_addr_i = '0;
  logic [2:0]  err_row_i = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        serr_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  ecc_err_logger u_dut (
    .clk(clk), .rst(rst), .sbe_i(sbe_i), .mbe_i(mbe_i),
    .err_addr_i(err_addr_i), .err_row_i(err_row_i),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .serr_o(serr_o)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] ea(input logic [31:0] a, input logic m, input logic s);
    return {a[31:12], 10'b0, m, s};
  endfunction

  function automatic logic [31:0] st(input logic mf, input logic [2:0] mr,
                                     input logic sf, input logic [2:0] sr);
    return {24'b0, mr, mf, sr, sf};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sbe_i = 0; mbe_i = 0; reg_we = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // drive one error, return serr in the following two cycles
  task automatic err(input logic s, input logic m, input logic [31:0] a,
                     input logic [2:0] r, output logic p1, output logic p2);
    @(negedge clk);
    sbe_i = s; mbe_i = m; err_addr_i = a; err_row_i = r;
    @(negedge clk);
    sbe_i = 0; mbe_i = 0;
    p1 = serr_o;
    @(negedge clk);
    p2 = serr_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    check("R1 serr after reset", {31'b0, serr_o}, 0);
    for (int i = 0; i < 4; i++) begin
      rd(i[1:0], d);
      check("R1 register reset value", d, 0);
    end
  endtask

  task automatic t_mode_off();
    logic [31:0] d; logic p1, p2;
    do_reset();
    wr(2, 32'h3);
    err(1, 1, 32'hABCD_E000, 3'd4, p1, p2);
    check("R2 no serr in mode 00", {30'b0, p1, p2}, 0);
    rd(0, d); check("R2 addr untouched", d, 0);
    rd(1, d); check("R2 status untouched", d, 0);
  endtask

  task automatic t_sbe();
    logic [31:0] d; logic p1, p2;
    do_reset();
    wr(3, 32'h2);
    err(1, 0, 32'h1234_5ABC, 3'd5, p1, p2);
    rd(0, d); check("R3 sbe addr", d, ea(32'h1234_5ABC, 0, 1));
    rd(1, d); check("R3 sbe status", d, st(0, 0, 1, 5));
    check("R9 no serr with cmd 0", {30'b0, p1, p2}, 0);
  endtask

  task automatic t_mbe();
    logic [31:0] d; logic p1, p2;
    do_reset();
    wr(3, 32'h3);
    err(0, 1, 32'hFFFF_F123, 3'd6, p1, p2);
    rd(0, d); check("R4 mbe addr", d, ea(32'hFFFF_F123, 1, 0));
    rd(1, d); check("R4 mbe status", d, st(1, 6, 0, 0));
  endtask

  task automatic t_sticky();
    logic [31:0] d; logic p1, p2;
    do_reset();
    wr(3, 32'h2);
    err(1, 0, 32'h0004_2000, 3'd2, p1, p2);
    err(1, 0, 32'h0777_7000, 3'd7, p1, p2);
    rd(0, d); check("R5 sbe addr frozen", d, ea(32'h0004_2000, 0, 1));
    rd(1, d); check("R5 sbe row frozen", d, st(0, 0, 1, 2));
    err(0, 1, 32'h0100_0000, 3'd3, p1, p2);
    err(0, 1, 32'h0200_0000, 3'd1, p1, p2);
    rd(0, d); check("R5 mbe addr frozen", d, ea(32'h0100_0000, 1, 1));
    rd(1, d); check("R5 mbe row frozen", d, st(1, 3, 1, 2));
  endtask

  task automatic t_overwrite();
    logic [31:0] d; logic p1, p2;
    do_reset();
    wr(3, 32'h2);
    err(1, 0, 32'h0000_1000, 3'd1, p1, p2);
    err(0, 1, 32'h8000_3FFF, 3'd4, p1, p2);
    rd(0, d); check("R6 mbe replaces sbe addr", d, ea(32'h8000_3FFF, 1, 1));
    rd(1, d); check("R6 status both rows", d, st(1, 4, 1, 1));
    do_reset();
    wr(3, 32'h2);
    err(0, 1, 32'h5555_5000, 3'd0, p1, p2);
    err(1, 0, 32'h6666_6000, 3'd7, p1, p2);
    rd(0, d); check("R6 sbe keeps mbe addr", d, ea(32'h5555_5000, 1, 1));
  endtask

  task automatic t_w1c();
    logic [31:0] d; logic p1, p2;
    do_reset();
    wr(3, 32'h1);
    err(1, 1, 32'h0ABC_0000, 3'd3, p1, p2);
    wr(0, 32'h0);
    rd(0, d); check("R7 zero write keeps flags", d, ea(32'h0ABC_0000, 1, 1));
    wr(1, 32'h0);
    rd(1, d); check("R7 zero write keeps status", d, st(1, 3, 1, 3));
    wr(0, 32'h1);
    rd(0, d); check("R7 clear sbe flag only", d, ea(32'h0ABC_0000, 1, 0));
    rd(1, d); check("R7 status independent", d, st(1, 3, 1, 3));
    wr(1, 32'h10);
    rd(1, d); check("R7 clear mbe occurred, rows kept", d, st(0, 3, 1, 3));
    wr(0, 32'h2);
    rd(0, d); check("R7 clear mbe flag", d, ea(32'h0ABC_0000, 0, 0));
  endtask

  task automatic t_race();
    logic [31:0] d;
    do_reset();
    wr(3, 32'h2);
    wr(2, 32'h1);
    @(negedge clk);
    sbe_i = 1; err_addr_i = 32'h0F00_0000; err_row_i = 3'd1;
    @(negedge clk);
    sbe_i = 0;
    // clear and new error together
    @(negedge clk);
    sbe_i = 1; err_addr_i = 32'h0E00_E000; err_row_i = 3'd3;
    reg_addr = 0; reg_wdata = 32'h1; reg_we = 1;
    @(negedge clk);
    sbe_i = 0; reg_we = 0;
    check("R8 serr on relog", {31'b0, serr_o}, 1);
    rd(0, d); check("R8 new error logged", d, ea(32'h0E00_E000, 0, 1));
    @(negedge clk);
    sbe_i = 1; err_addr_i = 32'h0D00_0000; err_row_i = 3'd6;
    reg_addr = 1; reg_wdata = 32'h1; reg_we = 1;
    @(negedge clk);
    sbe_i = 0; reg_we = 0;
    rd(1, d); check("R8 status relogged", d, st(0, 0, 1, 6));
  endtask

  task automatic t_serr();
    logic p1, p2;
    do_reset();
    wr(3, 32'h3);
    wr(2, 32'h1);
    err(1, 0, 32'h1000_0000, 3'd0, p1, p2);
    check("R9 sbe pulse one cycle", {30'b0, p1, p2}, 2);
    err(1, 0, 32'h2000_0000, 3'd0, p1, p2);
    check("R9 no pulse while flagged", {30'b0, p1, p2}, 0);
    err(0, 1, 32'h3000_0000, 3'd0, p1, p2);
    check("R9 mbe masked", {30'b0, p1, p2}, 0);
    wr(0, 32'h3);
    wr(2, 32'h2);
    err(0, 1, 32'h4000_0000, 3'd0, p1, p2);
    check("R9 mbe pulse", {30'b0, p1, p2}, 2);
    err(1, 0, 32'h5000_0000, 3'd0, p1, p2);
    check("R9 sbe masked", {30'b0, p1, p2}, 0);
  endtask

  task automatic t_modes();
    logic [31:0] d; logic p1, p2;
    for (int m = 1; m < 4; m++) begin
      do_reset();
      wr(3, m);
      err(1, 0, 32'h7000_0000 + m * 32'h1000, 3'(m), p1, p2);
      rd(0, d); check("R10 mode enables logging", d, ea(32'h7000_0000 + m * 32'h1000, 0, 1));
    end
  endtask

  task automatic t_readback();
    logic [31:0] d;
    do_reset();
    wr(2, 32'hFFFF_FFFE);
    rd(2, d); check("R11 command readback", d, 32'h2);
    wr(3, 32'hFFFF_FFFD);
    rd(3, d); check("R11 mode readback", d, 32'h1);
  endtask

  initial begin
    t_reset();
    t_mode_off();
    t_sbe();
    t_mbe();
    t_sticky();
    t_overwrite();
    t_w1c();
    t_race();
    t_serr();
    t_modes();
    t_readback();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule